// File: doc/BRIEF.md
# Grouped four-bit pattern recognizer

This block watches a serial bit stream one qualified bit at a time and splits it into back-to-back groups of four bits. On the cycle that delivers the last bit of a group, the single output pulses high when the group read, oldest bit first, is `1010` or `0110`. Any other group leaves the output low. The machine then returns to its idle state, ready for the first bit of the next group. Groups never overlap, so a match that straddles two groups is not reported.

Inside is a reduced seven-state Mealy machine in a 3-bit register. The state codes are chosen so that states with a common successor or a common predecessor differ in few bits. A qualifier input marks which cycles carry a real bit. On cycles without it the machine holds its state and the output stays low. A synchronous reset drops any partial group.

Top module: `grp4_recognizer`

## Requirements
- R1: While `rst` is high at a rising clock edge, the machine returns to idle. The first qualified bit after `rst` falls is bit one of a new group.
- R2: `hit` is low on every cycle where `bit_vld` is low, including a cycle where the held partial group would match if `bit_in` were taken.
- R3: A group whose bits arrive in the order 1, 0, 1, 0 drives `hit` high in the cycle that presents its fourth qualified bit.
- R4: A group whose bits arrive in the order 0, 1, 1, 0 drives `hit` high in the cycle that presents its fourth qualified bit.
- R5: A group holding any of the other fourteen four-bit values leaves `hit` low on its fourth bit.
- R6: `hit` is low on the first, second and third qualified bit of every group. Grouping is fixed from reset and does not slide, so a match that spans two groups is not reported.
- R7: Cycles with `bit_vld` low do not advance the group. A group with idle cycles inserted between its bits gives the same result as the same group sent without gaps.
- R8: `hit` depends on the current state and the current input. It is valid in the same cycle as the fourth bit, with no added register stage.
- R9: A reset asserted partway through a group discards the bits already taken. Those bits cannot combine with bits sent after the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | High when `bit_in` carries a bit to be consumed |
| hit | output | 1 | High for one qualified cycle when a group matches |

## Verification
Stalling and detection can fall in the same cycle. This happens when the machine already holds a matching three-bit prefix and a cycle arrives with `bit_in` at 0 but `bit_vld` low. The bench provokes this by inserting idle cycles with data 0 in front of the closing bit of `1010` and `0110` groups. It expects `hit` to stay low on every idle cycle and to rise only on the later qualified bit. A reset is also issued while a matching prefix is held, with a qualified 0 presented during reset. That case expects no pulse at all.

// File: rtl/grp4_recognizer.sv
module grp4_recognizer (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic hit
);

  typedef enum logic [2:0] {
    ST_IDLE  = 3'b000,
    ST_LEAD0 = 3'b001,
    ST_LEAD1 = 3'b101,
    ST_SAME  = 3'b011,
    ST_DIFF  = 3'b111,
    ST_DEAD  = 3'b010,
    ST_ARMED = 3'b110
  } st_t;

  st_t state, nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (bit_vld) nxt = bit_in ? ST_LEAD1 : ST_LEAD0;
      ST_LEAD0: if (bit_vld) nxt = bit_in ? ST_DIFF  : ST_SAME;
      ST_LEAD1: if (bit_vld) nxt = bit_in ? ST_SAME  : ST_DIFF;
      ST_SAME:  if (bit_vld) nxt = ST_DEAD;
      ST_DIFF:  if (bit_vld) nxt = bit_in ? ST_ARMED : ST_DEAD;
      ST_DEAD,
      ST_ARMED: if (bit_vld) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  assign hit = bit_vld & ~bit_in & (state == ST_ARMED);

  logic [1:0] grp_pos;
  always_ff @(posedge clk) begin
    if (rst)          grp_pos <= 2'd0;
    else if (bit_vld) grp_pos <= grp_pos + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (state == ST_IDLE));

  p_hold_stall_r7: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(state));

  p_hit_last_bit_r6: assert property (@(posedge clk) disable iff (rst)
    hit |-> (grp_pos == 2'd3));

  p_group_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && grp_pos == 2'd3) |=> (state == ST_IDLE));

endmodule

// File: tb/tb_grp4_recognizer.sv
module tb_grp4_recognizer;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic hit;

  grp4_recognizer dut (.clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .hit(hit));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct { bit exp; string tag; } item_t;
  item_t sb[$];

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [3:0] m_grp = 4'd0;
  int m_cnt = 0;

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  task automatic drive(input bit b, input bit v, input string hint = "");
    item_t it;
    string t;
    @(negedge clk);
    rst = 1'b0; bit_in = b; bit_vld = v;
    it.exp = 1'b0;
    if (v) begin
      m_grp = {m_grp[2:0], b};
      m_cnt++;
      if (m_cnt == 4) begin
        it.exp = (m_grp == 4'b1010) || (m_grp == 4'b0110);
        if (m_grp == 4'b1010)      t = "R3/R8";
        else if (m_grp == 4'b0110) t = "R4/R8";
        else                       t = "R5";
        m_cnt = 0;
      end else t = "R6";
    end else t = "R2";
    it.tag = (hint == "") ? t : {hint, "/", t};
    sb.push_back(it);
  endtask

  task automatic send_group(input logic [3:0] g, input string hint = "");
    for (int i = 3; i >= 0; i--) drive(g[i], 1'b1, hint);
  endtask

  task automatic do_reset();
    item_t it;
    @(negedge clk);
    rst = 1'b1; bit_vld = 1'b0;
    @(negedge clk);
    bit_vld = 1'b1; bit_in = 1'b0;
    it.exp = 1'b0; it.tag = "R1/R9";
    sb.push_back(it);
    m_cnt = 0; m_grp = 4'd0;
  endtask

  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        n_checks++;
        if (hit !== it.exp) begin
          n_fail++;
          $display("FAIL %s: hit=%b expected %b at %0t", it.tag, hit, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run still active, actual hung expected finished");
      finish_up();
    end
  end

  initial begin
    do_reset();
    // R3 R4 R5: sample stream
    send_group(4'b0010); send_group(4'b0110); send_group(4'b1100);
    send_group(4'b1010); send_group(4'b0011);
    // R5: every value
    for (int g = 0; g < 16; g++) send_group(g[3:0]);
    // R6: patterns straddling groups must not hit
    send_group(4'b0101); send_group(4'b0000, "R6");
    send_group(4'b1011); send_group(4'b0000, "R6");
    send_group(4'b0011); send_group(4'b0000, "R6");
    // R2 R7: stalls with data 0 while the prefix matches
    drive(1, 1, "R7"); drive(0, 0); drive(0, 1, "R7"); drive(1, 0);
    drive(1, 1, "R7"); drive(0, 0); drive(0, 0); drive(0, 1, "R7");
    drive(0, 1, "R7"); drive(1, 1, "R7"); drive(1, 1, "R7");
    drive(0, 0); drive(0, 0); drive(0, 0); drive(0, 1, "R7");
    // R9: reset while a matching prefix is held
    drive(1, 1); drive(0, 1); drive(1, 1);
    do_reset();
    drive(0, 1, "R9"); drive(0, 1, "R9"); drive(0, 1, "R9"); drive(0, 1, "R9");
    send_group(4'b0110, "R9");
    drive(0, 1); drive(1, 1);
    do_reset();
    send_group(4'b1010, "R1");
    // random traffic
    for (int i = 0; i < 800; i++) drive(1'($urandom), ($urandom % 4) != 0);
    @(negedge clk); bit_vld = 1'b0;
    while (sb.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule